// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits on the bus side of a processor front end. It keeps a 16-bit code segment and a 16-bit fetch offset. From these it forms a 20-bit byte address: the segment times sixteen plus the offset. It reads 16-bit words from a synchronous memory port and splits each word into bytes. The bytes go into a six-entry byte FIFO, which the execution side drains one byte at a time. Fetching runs on its own and overlaps with consumption, so the queue refills while bytes are being popped.

A taken branch raises the flush input. In one cycle this empties the queue, loads a new segment and offset, and cancels any word fetch that is still outstanding. If the new offset is odd, the first fetch queues only the upper half of its word. From then on the offset is even and fetches queue two bytes at a time. The offset wraps within its 64 KiB window, and the segment stays as it is.

Both data paths use valid/ready, with these back-pressure rules:
- **Request path:** `mem_req_o`/`mem_gnt_i` form a valid/ready pair. Once raised, the request stays up with a stable address until it is granted or a flush withdraws it.
- **Response path:** the response path (`mem_rvalid_i`) has no ready signal. The block reserves queue space before it requests, so it can always take the word.
- **Consumer path:** the consumer side is a valid/ready pair. A byte leaves when `q_valid_o` and `q_ready_i` are both high.

Top module: `prefetch_byte_queue`

## Requirements
- R1: After reset the queue is empty (`q_valid_o` low), and a fetch is requested at once for segment `RESET_SEG` and offset `RESET_OFF`.
- R2: The physical address is (segment × 16 + offset) mod 2^20. `mem_addr_o` carries it with bit 0 forced to 0. In the returned word, bits [7:0] hold the byte at the even address and bits [15:8] hold the byte at the odd address.
- R3: `mem_req_o` is high exactly when no fetch is outstanding and the queue holds at most 4 bytes. A raised, ungranted request stays high with a stable address unless a flush occurs. At most one fetch is outstanding: the grant happens before the response, and the response arrives at least one cycle after the grant.
- R4: A response for an even offset pushes bits [7:0] and then bits [15:8], and the offset advances by 2.
- R5: A response for an odd offset pushes only bits [15:8], and the offset advances by 1, which makes it even.
- R6: The offset wraps modulo 65536, and the segment is unchanged by the wrap.
- R7: Bytes leave in the order they were pushed. `q_valid_o` is high exactly when the queue is non-empty, and `q_byte_o` is the oldest byte. A pop takes place on a cycle with `q_valid_o` and `q_ready_i` both high. `q_ready_i` while the queue is empty has no effect.
- R8: A cycle with `flush_i` high leaves the queue empty on the next cycle and loads `flush_seg_i`/`flush_off_i`. A pop in that cycle is ignored. Any fetch granted before or during that cycle queues nothing.
- R9: A push and a pop can happen in the same cycle. The queue never exceeds 6 bytes. With no pops and an even start, it fills to exactly 6 and then stops requesting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Empty the queue and restart fetching |
| flush_seg_i | input | 16 | Code segment loaded on flush |
| flush_off_i | input | 16 | Fetch offset loaded on flush |
| mem_req_o | output | 1 | Word fetch request (valid) |
| mem_gnt_i | input | 1 | Memory accepts the request (ready) |
| mem_addr_o | output | 20 | Word-aligned physical byte address |
| mem_rvalid_i | input | 1 | Read data is returned this cycle |
| mem_rdata_i | input | 16 | Returned word, even byte in [7:0] |
| q_valid_o | output | 1 | Queue holds at least one byte |
| q_byte_o | output | 8 | Oldest queued byte |
| q_ready_i | input | 1 | Consumer takes the oldest byte |

## Verification
The bench targets these cases:
- **Odd-offset entry.** A design that queued both lanes would hand the consumer a byte from before the branch target. A design that advanced by two would skip a byte.
- **Lane order.** Swapped lanes show up at once, because every byte in the memory model differs from its neighbour.
- **Offset wrap.** A start just below 0xFFFF crosses the 64 KiB boundary. A design that carried into the segment would fetch from a shifted region. A second start near the top of the 20-bit space checks that the address sum truncates.
- **Flush races.** Flushes land in the grant cycle, while a response is pending, and in the very cycle the response returns. Each of these would otherwise leak stale bytes into the queue.
- **Full queue.** A stalled consumer shows whether the design requests with too little space, which would overflow the sixth slot, or stops too early and wastes a slot.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef enum logic [1:0] {
    FETCH_ISSUE = 2'd0,
    FETCH_WAIT  = 2'd1,
    FETCH_DROP  = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/pfq_addr.sv
module pfq_addr #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int ADDR_W    = 20
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] word_addr_o
);
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(1);

  logic [ADDR_W-1:0] seg_ext;
  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] sum;

  // segment scaled by the shift, offset zero-extended, sum truncated
  assign seg_ext     = ADDR_W'(seg_i) << SEG_SHIFT;
  assign off_ext     = ADDR_W'(off_i);
  assign sum         = seg_ext + off_ext;
  assign word_addr_o = sum & WORD_MASK;
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch import pfq_pkg::*; #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int ADDR_W    = 20,
  parameter int BYTE_W    = 8,
  parameter int DEPTH     = 6,
  parameter int CNT_W     = 3,
  parameter logic [SEG_W-1:0] RESET_SEG = '1,
  parameter logic [OFF_W-1:0] RESET_OFF = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush_i,
  input  logic [SEG_W-1:0]    flush_seg_i,
  input  logic [OFF_W-1:0]    flush_off_i,
  input  logic [CNT_W-1:0]    fill_i,
  output logic                mem_req_o,
  input  logic                mem_gnt_i,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic                mem_rvalid_i,
  input  logic [2*BYTE_W-1:0] mem_rdata_i,
  output logic [1:0]          push_n_o,
  output logic [BYTE_W-1:0]   push_b0_o,
  output logic [BYTE_W-1:0]   push_b1_o
);
  localparam logic [CNT_W-1:0] FILL_LIMIT = CNT_W'(DEPTH - 2);

  fetch_state_e     state_q, state_d;
  logic [SEG_W-1:0] seg_q, seg_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic             space_ok;
  logic             accept;

  pfq_addr #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)
  ) u_addr (
    .seg_i      (seg_q),
    .off_i      (off_q),
    .word_addr_o(mem_addr_o)
  );

  assign space_ok  = (fill_i <= FILL_LIMIT);
  assign mem_req_o = (state_q == FETCH_ISSUE) && space_ok;
  assign accept    = mem_req_o && mem_gnt_i;

  always_comb begin
    state_d   = state_q;
    seg_d     = seg_q;
    off_d     = off_q;
    push_n_o  = 2'd0;
    push_b0_o = mem_rdata_i[BYTE_W-1:0];
    push_b1_o = mem_rdata_i[2*BYTE_W-1:BYTE_W];
    unique case (state_q)
      FETCH_ISSUE: begin
        if (accept) state_d = flush_i ? FETCH_DROP : FETCH_WAIT;
      end
      FETCH_WAIT: begin
        if (mem_rvalid_i) begin
          state_d = FETCH_ISSUE;
          if (!flush_i) begin
            if (off_q[0]) begin
              push_n_o  = 2'd1;
              push_b0_o = mem_rdata_i[2*BYTE_W-1:BYTE_W];
              off_d     = off_q + OFF_W'(1);
            end else begin
              push_n_o  = 2'd2;
              off_d     = off_q + OFF_W'(2);
            end
          end
        end else if (flush_i) begin
          state_d = FETCH_DROP;
        end
      end
      FETCH_DROP: begin
        if (mem_rvalid_i) state_d = FETCH_ISSUE;
      end
      default: state_d = FETCH_ISSUE;
    endcase
    if (flush_i) begin
      seg_d = flush_seg_i;
      off_d = flush_off_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FETCH_ISSUE;
      seg_q   <= RESET_SEG;
      off_q   <= RESET_OFF;
    end else begin
      state_q <= state_d;
      seg_q   <= seg_d;
      off_q   <= off_d;
    end
  end

  // R3: a waiting request holds with a stable address
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_gnt_i && !flush_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R3: no second request right after a grant
  assert_single_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_gnt_i) |=> !mem_req_o);

  // R5: an odd fetch leaves the offset word aligned
  assert_align_after_odd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FETCH_WAIT && mem_rvalid_i && !flush_i && off_q[0]) |=> !off_q[0]);

  // R6: offset wraps to zero and keeps the segment
  assert_offset_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FETCH_WAIT && mem_rvalid_i && !flush_i && off_q == '1)
      |=> (off_q == '0 && $stable(seg_q)));
endmodule

// File: rtl/pfq_fifo.sv
module pfq_fifo #(
  parameter int DEPTH  = 6,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [1:0]        push_n_i,
  input  logic [BYTE_W-1:0] push_b0_i,
  input  logic [BYTE_W-1:0] push_b1_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [CNT_W-1:0]  fill_o
);
  logic [BYTE_W-1:0] slot_q [DEPTH];
  logic [BYTE_W-1:0] slot_d [DEPTH];
  logic [CNT_W-1:0]  fill_q, fill_d;
  logic [CNT_W-1:0]  base;
  logic              pop_ok;

  always_comb begin
    pop_ok = pop_i && (fill_q != '0) && !flush_i;
    base   = pop_ok ? fill_q - CNT_W'(1) : fill_q;
    for (int i = 0; i < DEPTH; i++) slot_d[i] = slot_q[i];
    if (pop_ok) begin
      for (int i = 0; i < DEPTH - 1; i++) slot_d[i] = slot_q[i + 1];
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (push_n_i != 2'd0 && i == int'(base))     slot_d[i] = push_b0_i;
      if (push_n_i == 2'd2 && i == int'(base) + 1) slot_d[i] = push_b1_i;
    end
    fill_d = flush_i ? '0 : base + CNT_W'(push_n_i);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) slot_q[g] <= slot_d[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= fill_d;
  end

  assign valid_o = (fill_q != '0);
  assign byte_o  = slot_q[0];
  assign fill_o  = fill_q;

  // R9: pushes never take the queue past its depth
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && push_n_i != 2'd0)
      |-> (int'(fill_q) + int'(push_n_i) - int'(pop_ok) <= DEPTH));

  // R8: flush leaves the queue empty
  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (fill_q == '0));

  // R7: pop on empty queue changes nothing
  assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q == '0 && pop_i && push_n_i == 2'd0 && !flush_i) |=> (fill_q == '0));
endmodule

// File: rtl/prefetch_byte_queue.sv
module prefetch_byte_queue #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int ADDR_W    = 20,
  parameter int BYTE_W    = 8,
  parameter int DEPTH     = 6,
  parameter logic [SEG_W-1:0] RESET_SEG = '1,
  parameter logic [OFF_W-1:0] RESET_OFF = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush_i,
  input  logic [SEG_W-1:0]    flush_seg_i,
  input  logic [OFF_W-1:0]    flush_off_i,
  output logic                mem_req_o,
  input  logic                mem_gnt_i,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic                mem_rvalid_i,
  input  logic [2*BYTE_W-1:0] mem_rdata_i,
  output logic                q_valid_o,
  output logic [BYTE_W-1:0]   q_byte_o,
  input  logic                q_ready_i
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]  fill;
  logic [1:0]        push_n;
  logic [BYTE_W-1:0] push_b0;
  logic [BYTE_W-1:0] push_b1;

  pfq_fetch #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W),
    .BYTE_W(BYTE_W), .DEPTH(DEPTH), .CNT_W(CNT_W),
    .RESET_SEG(RESET_SEG), .RESET_OFF(RESET_OFF)
  ) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush_i),
    .flush_seg_i (flush_seg_i),
    .flush_off_i (flush_off_i),
    .fill_i      (fill),
    .mem_req_o   (mem_req_o),
    .mem_gnt_i   (mem_gnt_i),
    .mem_addr_o  (mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i (mem_rdata_i),
    .push_n_o    (push_n),
    .push_b0_o   (push_b0),
    .push_b1_o   (push_b1)
  );

  pfq_fifo #(
    .DEPTH(DEPTH), .BYTE_W(BYTE_W), .CNT_W(CNT_W)
  ) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush_i  (flush_i),
    .push_n_i (push_n),
    .push_b0_i(push_b0),
    .push_b1_i(push_b1),
    .pop_i    (q_ready_i),
    .valid_o  (q_valid_o),
    .byte_o   (q_byte_o),
    .fill_o   (fill)
  );
endmodule

// File: tb/prefetch_byte_queue_tb.sv
`timescale 1ns/1ps
module prefetch_byte_queue_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic [15:0] flush_seg_i = '0;
  logic [15:0] flush_off_i = '0;
  logic        mem_req_o;
  logic        mem_gnt_i = 1'b0;
  logic [19:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [15:0] mem_rdata_i = '0;
  logic        q_valid_o;
  logic [7:0]  q_byte_o;
  logic        q_ready_i = 1'b0;

  always #10 clk = ~clk;

  prefetch_byte_queue u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_seg_i(flush_seg_i),
    .flush_off_i(flush_off_i), .mem_req_o(mem_req_o), .mem_gnt_i(mem_gnt_i),
    .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .q_valid_o(q_valid_o), .q_byte_o(q_byte_o), .q_ready_i(q_ready_i)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // reference model state
  logic [7:0]  mq[$];
  logic [15:0] mseg = 16'hFFFF;
  logic [15:0] moff = 16'h0000;
  bit          busy = 1'b0;
  bit          stale = 1'b0;
  int          lat = 0;
  logic [19:0] baddr = '0;
  bit          last_flush = 1'b0;
  string       tag = "R4";

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {4'h0, s} * 20'd16 + {4'h0, o};
  endfunction

  function automatic logic [7:0] bat(input logic [19:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ {4'h0, a[19:16]};
  endfunction

  task automatic chk(input bit ok, input string t, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", t, what, act, exp);
    end
  endtask

  task automatic cycle(input bit do_flush, input logic [15:0] fs,
                       input logic [15:0] fo, input int pop_pct);
    bit d_req, d_gnt, d_rv, d_rdy;
    logic [19:0] d_addr;
    @(negedge clk);
    chk(q_valid_o === (mq.size() > 0), "R7", "q_valid", 32'(q_valid_o), 32'(mq.size() > 0));
    if (mq.size() > 0)
      chk(q_byte_o === mq[0], tag, "q_byte", 32'(q_byte_o), 32'(mq[0]));
    chk(mem_req_o === (!busy && mq.size() <= 4), "R3", "mem_req",
        32'(mem_req_o), 32'(!busy && mq.size() <= 4));
    if (mem_req_o)
      chk(mem_addr_o === (phys(mseg, moff) & 20'hFFFFE), "R2", "mem_addr",
          32'(mem_addr_o), 32'(phys(mseg, moff) & 20'hFFFFE));
    if (last_flush)
      chk(q_valid_o === 1'b0, "R8", "valid after flush", 32'(q_valid_o), 32'd0);
    d_req  = mem_req_o;
    d_addr = mem_addr_o;
    d_gnt  = mem_req_o && !busy && ($urandom % 100 < 70);
    d_rv   = busy && (lat == 0);
    d_rdy  = ($urandom % 100) < pop_pct;
    mem_gnt_i    = d_gnt;
    mem_rvalid_i = d_rv;
    mem_rdata_i  = d_rv ? {bat(baddr | 20'd1), bat(baddr)} : 16'(($urandom));
    q_ready_i    = d_rdy;
    flush_i      = do_flush;
    flush_seg_i  = fs;
    flush_off_i  = fo;
    @(posedge clk);
    #1;
    if (do_flush) begin
      mq.delete();
      mseg = fs;
      moff = fo;
    end else begin
      if (d_rdy && mq.size() > 0) void'(mq.pop_front());
      if (d_rv && !stale) begin
        if (moff[0]) begin
          mq.push_back(bat(phys(mseg, moff)));
          moff = moff + 16'd1;
        end else begin
          mq.push_back(bat(phys(mseg, moff)));
          mq.push_back(bat(phys(mseg, moff) + 20'd1));
          moff = moff + 16'd2;
        end
      end
    end
    if (d_rv) begin
      busy = 1'b0;
      stale = 1'b0;
    end
    if (d_req && d_gnt) begin
      busy = 1'b1;
      lat = int'($urandom % 4);
      baddr = d_addr;
      stale = do_flush;
    end else if (busy) begin
      if (do_flush) stale = 1'b1;
      if (lat > 0) lat--;
    end
    last_flush = do_flush;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(q_valid_o === 1'b0, "R1", "q_valid at reset", 32'(q_valid_o), 32'd0);
    chk(mem_req_o === 1'b1, "R1", "mem_req at reset", 32'(mem_req_o), 32'd1);
    chk(mem_addr_o === 20'hFFFF0, "R1", "addr at reset", 32'(mem_addr_o), 32'hFFFF0);
    tag = "R1";
    for (int i = 0; i < 30; i++) cycle(1'b0, '0, '0, 50);
    // R4: even start
    tag = "R4";
    cycle(1'b1, 16'h1000, 16'h0100, 50);
    for (int i = 0; i < 60; i++) cycle(1'b0, '0, '0, 50);
    // R5: odd start
    tag = "R5";
    cycle(1'b1, 16'h448A, 16'h2345, 40);
    for (int i = 0; i < 60; i++) cycle(1'b0, '0, '0, 60);
    // R6: offset wraps inside the segment
    tag = "R6";
    cycle(1'b1, 16'h0123, 16'hFFFB, 50);
    for (int i = 0; i < 50; i++) cycle(1'b0, '0, '0, 70);
    // R2: 20-bit sum truncates
    tag = "R2";
    cycle(1'b1, 16'hFFFF, 16'hFFF8, 50);
    for (int i = 0; i < 40; i++) cycle(1'b0, '0, '0, 60);
    // R9: stalled consumer fills to six
    tag = "R9";
    cycle(1'b1, 16'h2000, 16'h0040, 0);
    for (int i = 0; i < 40; i++) cycle(1'b0, '0, '0, 0);
    @(negedge clk);
    chk(mem_req_o === 1'b0, "R9", "no request when full", 32'(mem_req_o), 32'd0);
    chk(q_valid_o === 1'b1, "R9", "full queue valid", 32'(q_valid_o), 32'd1);
    for (int i = 0; i < 20; i++) cycle(1'b0, '0, '0, 100);
    // R7: pops on an empty queue
    tag = "R7";
    cycle(1'b1, 16'h3000, 16'h0020, 100);
    for (int i = 0; i < 40; i++) cycle(1'b0, '0, '0, 100);
    // R8: flushes racing grants and responses
    tag = "R8";
    for (int i = 0; i < 400; i++)
      cycle(($urandom % 100) < 12, 16'($urandom), 16'($urandom), 60);
    for (int i = 0; i < 20; i++) cycle(1'b0, '0, '0, 100);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL R7 watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule